// File: doc/BRIEF.md
# EEPROM Write-Guard and Status Unit

This unit decides whether a serial EEPROM controller may commit a write. It keeps a write-enable latch, a two-bit block-protect code and an enable bit for the external write-protect pin. Decoded command strobes come in from the instruction decoder, together with the first and last address of the targeted page, the proposed status value and the level of the write-protect pin. For each status write or array write, the unit either grants it or refuses it. A granted write raises a one-cycle commit pulse and starts a self-timed write cycle. The length of that cycle is a parameter counted in clock cycles.

The unit also produces the status byte that a status read returns. While a write cycle runs, the busy flag is high and the status byte reads as all ones. Storage of array data is handled elsewhere.

Top module: `nvm_guard_unit`

## Requirements
- R1: After reset the status byte reads 0x00, and both busy and commitGrant are low.
- R2: A set-enable strobe makes status bit 1 read 1. A clear-enable strobe makes it read 0 at any level of wpPin.
- R3: When idle, the status byte is {protect-pin enable, 3'b000, block code[1:0], latch, 1'b0}. Bits 6:4 and bit 0 read 0 even when the loaded value had them set.
- R4: A granted write raises busy and commitGrant in the same cycle. busy then stays high for exactly WRITE_CYCLES cycles, and the status byte reads 0xFF for that whole time.
- R5: A status or array write requested while the latch is clear is refused: no commitGrant, no busy.
- R6: A granted status write loads the protect-pin enable from newStatus[7] and the block code from newStatus[3:2]. commitGrant is a single-cycle pulse.
- R7: Hardware lock is active only when wpPin is 0 and the protect-pin enable is 1. While the lock is active, status writes are refused and the stored bits stay as they were. With wpPin at 1, or with the enable at 0, status writes are granted.
- R8: Block code 01 protects addresses 0x6000-0x7FFF, 10 protects 0x4000-0x7FFF, 11 protects 0x0000-0x7FFF, and 00 protects nothing (15-bit addresses). An array write whose span touches a protected address is refused as a whole.
- R9: The latch clears when a granted write cycle ends. It also clears on a refused write attempt.
- R10: All command strobes are ignored while busy is high.
- R11: When several strobes arrive in the same cycle, only one acts, in this order of precedence: clear-enable, set-enable, status write, array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdSetWen | input | 1 | Set write-enable latch strobe |
| cmdClrWen | input | 1 | Clear write-enable latch strobe |
| cmdWrStatus | input | 1 | Status write request strobe |
| cmdWrArray | input | 1 | Array page write request strobe |
| spanFirst | input | ADDR_W | First address of targeted page |
| spanLast | input | ADDR_W | Last address of targeted page |
| newStatus | input | 8 | Proposed status value |
| wpPin | input | 1 | External write-protect pin level |
| statusByte | output | 8 | Status read-back value |
| commitGrant | output | 1 | One-cycle grant pulse for a write |
| busy | output | 1 | Write cycle in progress |

## Verification
The hardest state to reach is the hardware lock. The protect-pin enable can only be set by a status write that was itself granted, and that requires a full timed cycle to finish with the pin held high. After that, the pin must go low for the refused write. The stimulus therefore runs a granted status write with wpPin high that sets the enable and the top block code. It waits out the busy window, and only then lowers wpPin and attempts a second status write. That attempt must be refused, and it must leave the enable and the block code unchanged. Each array-range boundary is probed with spans that end just below the protected bound and spans that straddle it.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  localparam int STAT_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
    logic startCycle;
  } guardStrobe_t;
endpackage

// File: rtl/nvm_guard_dp.sv
module nvm_guard_dp
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  guardStrobe_t        strb,
  input  logic [STAT_W-1:0]   newStatus,
  input  logic [ADDR_W-1:0]   spanFirst,
  input  logic [ADDR_W-1:0]   spanLast,
  input  logic                wpPin,
  output logic                wel,
  output logic                busy,
  output logic                hwLock,
  output logic                spanHit,
  output logic                cycleDone,
  output logic [STAT_W-1:0]   statusByte
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] BOUND_QTR  = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] BOUND_HALF = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [CNT_W-1:0]  CNT_LOAD   = CNT_W'(WRITE_CYCLES - 1);

  logic [1:0]       blkCode;
  logic             pinEn;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] spanTop;
  logic [ADDR_W-1:0] lowBound;

  // configuration bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blkCode <= 2'b00;
      pinEn   <= 1'b0;
    end else if (strb.loadStat) begin
      blkCode <= newStatus[3:2];
      pinEn   <= newStatus[7];
    end
  end

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wel <= 1'b0;
    else if (strb.clrWel)  wel <= 1'b0;
    else if (strb.setWel)  wel <= 1'b1;
  end

  // self-timed cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strb.startCycle) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (cycleDone) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cycleDone = busy && (cnt == '0);
  assign hwLock    = pinEn && !wpPin;

  // protected range: everything at or above lowBound when code != 0
  always_comb begin
    spanTop = (spanLast > spanFirst) ? spanLast : spanFirst;
    unique case (blkCode)
      2'b01:   lowBound = BOUND_QTR;
      2'b10:   lowBound = BOUND_HALF;
      default: lowBound = '0;
    endcase
    spanHit = (blkCode != 2'b00) && (spanTop >= lowBound);
  end

  assign statusByte = busy ? {STAT_W{1'b1}}
                           : {pinEn, 3'b000, blkCode, wel, 1'b0};
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdSetWen,
  input  logic         cmdClrWen,
  input  logic         cmdWrStatus,
  input  logic         cmdWrArray,
  input  logic         wel,
  input  logic         busy,
  input  logic         hwLock,
  input  logic         spanHit,
  input  logic         cycleDone,
  output guardStrobe_t strb,
  output logic         commitGrant
);
  logic grantNow;

  always_comb begin
    strb     = '0;
    grantNow = 1'b0;
    if (busy) begin
      strb.clrWel = cycleDone;
    end else if (cmdClrWen) begin
      strb.clrWel = 1'b1;
    end else if (cmdSetWen) begin
      strb.setWel = 1'b1;
    end else if (cmdWrStatus) begin
      if (wel && !hwLock) begin
        grantNow        = 1'b1;
        strb.loadStat   = 1'b1;
        strb.startCycle = 1'b1;
      end else begin
        strb.clrWel = 1'b1;
      end
    end else if (cmdWrArray) begin
      if (wel && !spanHit) begin
        grantNow        = 1'b1;
        strb.startCycle = 1'b1;
      end else begin
        strb.clrWel = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commitGrant <= 1'b0;
    else        commitGrant <= grantNow;
  end
endmodule

// File: rtl/nvm_guard_unit.sv
module nvm_guard_unit
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdSetWen,
  input  logic              cmdClrWen,
  input  logic              cmdWrStatus,
  input  logic              cmdWrArray,
  input  logic [ADDR_W-1:0] spanFirst,
  input  logic [ADDR_W-1:0] spanLast,
  input  logic [7:0]        newStatus,
  input  logic              wpPin,
  output logic [7:0]        statusByte,
  output logic              commitGrant,
  output logic              busy
);
  guardStrobe_t strb;
  logic wel, hwLock, spanHit, cycleDone;

  nvm_guard_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdSetWen(cmdSetWen), .cmdClrWen(cmdClrWen),
    .cmdWrStatus(cmdWrStatus), .cmdWrArray(cmdWrArray),
    .wel(wel), .busy(busy), .hwLock(hwLock), .spanHit(spanHit),
    .cycleDone(cycleDone), .strb(strb), .commitGrant(commitGrant)
  );

  nvm_guard_dp #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .newStatus(newStatus),
    .spanFirst(spanFirst), .spanLast(spanLast), .wpPin(wpPin),
    .wel(wel), .busy(busy), .hwLock(hwLock), .spanHit(spanHit),
    .cycleDone(cycleDone), .statusByte(statusByte)
  );
endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmdSetWen,
  input logic       cmdClrWen,
  input logic       cmdWrStatus,
  input logic       cmdWrArray,
  input logic       wpPin,
  input logic [7:0] statusByte,
  input logic       commitGrant,
  input logic       busy
);
  AST_BUSY_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> statusByte == 8'hFF); // R4
  AST_IDLE_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (statusByte[6:4] == 3'b000 && !statusByte[0])); // R3
  AST_GRANT_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commitGrant |-> busy); // R4
  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commitGrant |=> !commitGrant); // R6
  AST_CLR_ANY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmdClrWen) |=> !statusByte[1]); // R2
  AST_NEED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !statusByte[1] && !cmdSetWen && !cmdClrWen && (cmdWrStatus || cmdWrArray))
      |=> (!commitGrant && !busy)); // R5
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wpPin && statusByte[7] && cmdWrStatus && !cmdSetWen && !cmdClrWen)
      |=> (!commitGrant && $stable(statusByte[7:2]))); // R7
  AST_REFUSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmdWrArray && !cmdSetWen && !cmdClrWen && !cmdWrStatus)
      |=> (commitGrant || !statusByte[1])); // R9
endmodule

bind nvm_guard_unit nvm_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmdSetWen(cmdSetWen), .cmdClrWen(cmdClrWen),
  .cmdWrStatus(cmdWrStatus), .cmdWrArray(cmdWrArray), .wpPin(wpPin),
  .statusByte(statusByte), .commitGrant(commitGrant), .busy(busy)
);

// File: tb/nvm_guard_unit_bench.sv
`timescale 1ns/1ps
module nvm_guard_unit_bench;
  localparam int ADDR_W = 15;
  localparam int WC     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdSetWen = 0, cmdClrWen = 0, cmdWrStatus = 0, cmdWrArray = 0;
  logic [ADDR_W-1:0] spanFirst = '0, spanLast = '0;
  logic [7:0] newStatus = '0;
  logic wpPin = 1'b1;
  logic [7:0] statusByte;
  logic commitGrant, busy;

  always #10 clk = ~clk;

  nvm_guard_unit #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WC)) u_nvm_guard_unit (
    .clk(clk), .rst_n(rst_n), .cmdSetWen(cmdSetWen), .cmdClrWen(cmdClrWen),
    .cmdWrStatus(cmdWrStatus), .cmdWrArray(cmdWrArray),
    .spanFirst(spanFirst), .spanLast(spanLast), .newStatus(newStatus),
    .wpPin(wpPin), .statusByte(statusByte), .commitGrant(commitGrant), .busy(busy)
  );

  typedef struct {
    string      tag;
    logic       grant;
    logic       bsy;
    logic [7:0] stat;
  } expItem_t;

  expItem_t expQ[$];
  event probe;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // bench model of requirements
  logic       mWel = 0;
  logic [1:0] mBp = 0;
  logic       mPin = 0;

  function automatic logic [7:0] idleStat();
    return {mPin, 3'b000, mBp, mWel, 1'b0};
  endfunction

  // monitor: pops expectations and compares with outputs
  initial begin
    forever begin
      @(probe);
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        compared++;
        if (commitGrant !== e.grant || busy !== e.bsy || statusByte !== e.stat) begin
          mismatched++;
          $display("FAIL %s: got grant=%b busy=%b status=%h, expected grant=%b busy=%b status=%h",
                   e.tag, commitGrant, busy, statusByte, e.grant, e.bsy, e.stat);
        end
      end
    end
  end

  task automatic expectNow(string tag, logic g, logic b, logic [7:0] s);
    expItem_t e;
    e.tag = tag; e.grant = g; e.bsy = b; e.stat = s;
    expQ.push_back(e);
    ->probe;
    #0;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // driver: one command cycle, then checks against model
  task automatic issue(string tag, logic s, logic c, logic ws, logic wa,
                       logic [ADDR_W-1:0] f, logic [ADDR_W-1:0] l,
                       logic [7:0] ns, bit poke);
    logic g;
    logic [ADDR_W-1:0] top, bound;
    g = 0;
    @(negedge clk);
    cmdSetWen = s; cmdClrWen = c; cmdWrStatus = ws; cmdWrArray = wa;
    spanFirst = f; spanLast = l; newStatus = ns;
    if (c) mWel = 0;
    else if (s) mWel = 1;
    else if (ws) begin
      if (mWel && !(!wpPin && mPin)) begin
        g = 1; mPin = ns[7]; mBp = ns[3:2];
      end
      mWel = 0;
    end else if (wa) begin
      top = (l > f) ? l : f;
      bound = (mBp == 2'b01) ? 15'h6000 : (mBp == 2'b10) ? 15'h4000 : 15'h0000;
      if (mWel && !(mBp != 2'b00 && top >= bound)) g = 1;
      mWel = 0;
    end
    tick(1);
    cmdSetWen = 0; cmdClrWen = 0; cmdWrStatus = 0; cmdWrArray = 0;
    if (g) begin
      expectNow({tag, " grant"}, 1, 1, 8'hFF);
      if (poke) begin
        // R10: strobes while busy have no effect
        @(negedge clk);
        cmdSetWen = 1; cmdWrArray = 1;
        tick(1);
        cmdSetWen = 0; cmdWrArray = 0;
        expectNow("R10 busy ignores", 0, 1, 8'hFF);
        tick(WC - 2);
      end else begin
        tick(WC - 1);
      end
      expectNow("R4 last busy cycle", 0, 1, 8'hFF);
      tick(1);
      expectNow({tag, " R9 end of cycle"}, 0, 0, idleStat());
    end else begin
      expectNow(tag, 0, 0, idleStat());
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #35;
    expectNow("R1 reset state", 0, 0, 8'h00);
    @(negedge clk); rst_n = 1;
    tick(1);
    expectNow("R1 after release", 0, 0, 8'h00);

    issue("R5 array no latch", 0,0,0,1, 15'h0000, 15'h003F, 8'h00, 0);
    issue("R5 status no latch", 0,0,1,0, 0, 0, 8'h8C, 0);
    issue("R2 set latch", 1,0,0,0, 0, 0, 8'h00, 0);
    wpPin = 0;
    issue("R2 clear latch pin low", 0,1,0,0, 0, 0, 8'h00, 0);
    wpPin = 1;
    issue("R2 set latch again", 1,0,0,0, 0, 0, 8'h00, 0);
    issue("R6 R3 status write FD", 0,0,1,0, 0, 0, 8'hFD, 1);

    // locked: pin enable 1, pin low
    wpPin = 0;
    issue("R2 set for lock", 1,0,0,0, 0, 0, 8'h00, 0);
    issue("R7 locked status write", 0,0,1,0, 0, 0, 8'h00, 0);
    wpPin = 1;
    issue("R2 set unlocked", 1,0,0,0, 0, 0, 8'h00, 0);
    issue("R7 pin high status write 04", 0,0,1,0, 0, 0, 8'h04, 0);

    // quarter protection
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R8 below quarter", 0,0,0,1, 15'h5FC0, 15'h5FFF, 0, 0);
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R8 straddle quarter", 0,0,0,1, 15'h5FE0, 15'h603F, 0, 0);

    // half protection, pin low but enable 0
    wpPin = 0;
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R7 pin low enable 0 write 08", 0,0,1,0, 0, 0, 8'h08, 0);
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R8 below half", 0,0,0,1, 15'h3FC0, 15'h3FFF, 0, 0);
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R8 at half", 0,0,0,1, 15'h4000, 15'h403F, 0, 0);

    // all protected
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R6 write 0C", 0,0,1,0, 0, 0, 8'h0C, 0);
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R8 all protected low page", 0,0,0,1, 15'h0000, 15'h003F, 0, 0);
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R6 write 00", 0,0,1,0, 0, 0, 8'h00, 0);
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R8 none protected top page", 0,0,0,1, 15'h7FC0, 15'h7FFF, 0, 0);

    // precedence
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R11 clear beats set", 1,1,0,0, 0, 0, 0, 0);
    issue("R2 set", 1,0,0,0, 0, 0, 0, 0);
    issue("R11 set beats array", 1,0,0,1, 15'h0000, 15'h003F, 0, 0);
    issue("R11 status beats array", 0,0,1,1, 15'h0000, 15'h003F, 8'h84, 0);

    tick(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule